// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Port

This block gathers up to 32 interrupt request lines into a single processor interrupt line. Each line is fixed at elaboration time as either edge-triggered or level-sensitive through a kind mask parameter: a 1 bit makes the line edge-triggered and a 0 bit makes it level-sensitive. Kind bits at or above the configured line count are ignored. Each line's request is latched in a status bit and gated by an enable bit. Among the lines whose status and enable are both set, the lowest-numbered one is reported as a vector number. Two control bits gate the processor line.

Software uses a simple word-wide register port. Addresses are byte offsets, and a register is selected by the word index `reg_addr[4:2]`. Writes happen on a clock edge when `reg_wr` is high. Reads are combinational from `reg_addr`. The enable bits can be replaced with a single write, or changed atomically through write-one-to-set and write-one-to-clear registers. An acknowledge register clears latched requests.

The processor line is produced by a two-state machine:
- `LINE_IDLE` goes to `LINE_ACTIVE` when a request is present: at least one line is pending and both control bits are set.
- `LINE_ACTIVE` goes back to `LINE_IDLE` when the request disappears.
- The output is high only in `LINE_ACTIVE`.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, status, enable and the control register read 0, the vector register reads 0xFFFFFFFF, and `irq_out` is low.
- R2: A level-sensitive line that is high sets its status bit (offset 0x00) one clock later. A 1 written to that bit of the acknowledge register (offset 0x0C) makes the bit read 0 for exactly one cycle; if the line is still high, the bit reads 1 again after the next clock. The bit stays latched after the line falls, until it is acknowledged.
- R3: An edge-triggered line sets its status bit on a rising edge, one clock later. The bit stays set after the line falls and is cleared only by an acknowledge. A line held high after an acknowledge does not set the bit again.
- R4: Zero bits written to the acknowledge register have no effect. Writing 0xFFFFFFFF clears every latched request.
- R5: A 1 bit written to the set-enable register (offset 0x10) sets that enable bit, and a 1 bit written to the clear-enable register (offset 0x14) clears it. All other enable bits keep their values.
- R6: A write to the enable register (offset 0x08) replaces every enable bit. Enable bits at or above the line count always read 0.
- R7: The pending register (offset 0x04) reads status AND enable.
- R8: The vector register (offset 0x18) returns the index of the lowest-numbered pending line, or 0xFFFFFFFF when no line is pending.
- R9: `irq_out` is high in a cycle exactly when, one clock earlier, the pending register was nonzero and both control bits were set.
- R10: The control register (offset 0x1C) holds bit 0 (master enable) and bit 1 (hardware-interrupt enable). It reads back these written bits, and all its other bits read 0.
- R11: The following writes have no effect: writes to the status, pending and vector offsets, and writes whose `reg_addr[1:0]` is not zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_SRC | Interrupt request lines |
| reg_addr | input | 5 | Register byte offset |
| reg_wr | input | 1 | Write strobe, taken on a rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_out | output | 1 | Processor interrupt line |

## Verification
The sweep walks every enable pattern over an 8-line configuration while all requests are latched. A priority encoder biased the wrong way would report the wrong vector. A missing all-ones code would report line 0 when nothing is pending.

Several cases probe the acknowledge path:
- The one-cycle dip of a level-sensitive bit under acknowledge. A design that forgets the line is still high would leave the bit cleared.
- An edge-triggered line held high after an acknowledge. A design that treats it as a level would re-latch it.

Every control-bit combination is tried. A design that gates the line on only one control bit would raise `irq_out` too early.

Each set-enable and clear-enable bit is walked next to a neighbour. A non-atomic design would disturb the neighbour.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;

    // Word index of each register (byte offset >> 2)
    typedef enum logic [2:0] {
        SEL_STATUS  = 3'd0,
        SEL_PENDING = 3'd1,
        SEL_ENABLE  = 3'd2,
        SEL_ACK     = 3'd3,
        SEL_EN_SET  = 3'd4,
        SEL_EN_CLR  = 3'd5,
        SEL_VECTOR  = 3'd6,
        SEL_CTRL    = 3'd7
    } reg_sel_e;

    typedef enum logic {
        LINE_IDLE   = 1'b0,
        LINE_ACTIVE = 1'b1
    } line_state_e;

    localparam int unsigned WORD_W = 32;
    localparam logic [WORD_W-1:0] NO_VECTOR = '1;

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
    parameter int unsigned          NUM_SRC   = 32,
    parameter logic [31:0]          KIND_MASK = 32'h0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [NUM_SRC-1:0] ack_i,
    output logic [NUM_SRC-1:0] stat_o
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic stat_q;
        if (KIND_MASK[i]) begin : g_edge
            // Edge kind: latch on a rising edge; a new edge beats an acknowledge.
            logic req_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    req_q  <= 1'b0;
                    stat_q <= 1'b0;
                end else begin
                    req_q  <= req_i[i];
                    stat_q <= (req_i[i] & ~req_q) | (stat_q & ~ack_i[i]);
                end
            end
        end else begin : g_level
            // Level kind: an acknowledge clears the bit for one cycle; a still-high line relatches it.
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stat_q <= 1'b0;
                end else if (ack_i[i]) begin
                    stat_q <= 1'b0;
                end else begin
                    stat_q <= stat_q | req_i[i];
                end
            end
        end
        assign stat_o[i] = stat_q;
    end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int unsigned NUM_SRC = 32,
    localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] pend_i,
    output logic               any_o,
    output logic [IDX_W-1:0]   idx_o
);

    // Scan from the top down so the lowest-numbered pending line wins.
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_line_fsm.sv
module irq_line_fsm
    import irq_vector_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic irq_o
);

    line_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LINE_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_IDLE:   if (req_i)  state_d = LINE_ACTIVE;
            LINE_ACTIVE: if (!req_i) state_d = LINE_IDLE;
            default:                 state_d = LINE_IDLE;
        endcase
    end

    always_comb begin
        irq_o = 1'b0;
        unique case (state_q)
            LINE_IDLE:   irq_o = 1'b0;
            LINE_ACTIVE: irq_o = 1'b1;
            default:     irq_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_vector_pkg::*;
#(
    parameter int unsigned NUM_SRC   = 32,
    parameter logic [31:0] KIND_MASK = 32'hFFFF_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic [4:0]         reg_addr,
    input  logic               reg_wr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               irq_out
);

    localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    reg_sel_e            sel;
    logic                aligned;
    logic                wr_ok;
    logic [NUM_SRC-1:0]  ack_w;
    logic [NUM_SRC-1:0]  stat_w;
    logic [NUM_SRC-1:0]  en_q;
    logic [1:0]          mstr_q;
    logic [NUM_SRC-1:0]  pend_w;
    logic                any_w;
    logic [IDX_W-1:0]    idx_w;
    logic [31:0]         vec_w;
    logic                line_req;

    assign sel     = reg_sel_e'(reg_addr[4:2]);
    assign aligned = (reg_addr[1:0] == 2'b00);
    assign wr_ok   = reg_wr & aligned;
    assign ack_w   = (wr_ok && sel == SEL_ACK) ? reg_wdata[NUM_SRC-1:0] : '0;

    irq_src_bank #(
        .NUM_SRC   (NUM_SRC),
        .KIND_MASK (KIND_MASK)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (irq_in),
        .ack_i  (ack_w),
        .stat_o (stat_w)
    );

    // Enable and control registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            mstr_q <= 2'b00;
        end else if (wr_ok) begin
            unique case (sel)
                SEL_ENABLE: en_q   <= reg_wdata[NUM_SRC-1:0];
                SEL_EN_SET: en_q   <= en_q | reg_wdata[NUM_SRC-1:0];
                SEL_EN_CLR: en_q   <= en_q & ~reg_wdata[NUM_SRC-1:0];
                SEL_CTRL:   mstr_q <= reg_wdata[1:0];
                default:    ;
            endcase
        end
    end

    assign pend_w = stat_w & en_q;

    irq_prio_pick #(
        .NUM_SRC (NUM_SRC)
    ) u_pick (
        .pend_i (pend_w),
        .any_o  (any_w),
        .idx_o  (idx_w)
    );

    assign vec_w    = any_w ? 32'(idx_w) : NO_VECTOR;
    assign line_req = any_w & mstr_q[0] & mstr_q[1];

    irq_line_fsm u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (line_req),
        .irq_o (irq_out)
    );

    // Read mux
    always_comb begin
        reg_rdata = '0;
        if (aligned) begin
            unique case (sel)
                SEL_STATUS:  reg_rdata = 32'(stat_w);
                SEL_PENDING: reg_rdata = 32'(pend_w);
                SEL_ENABLE:  reg_rdata = 32'(en_q);
                SEL_VECTOR:  reg_rdata = vec_w;
                SEL_CTRL:    reg_rdata = {30'd0, mstr_q};
                default:     reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
    parameter int unsigned NUM_SRC   = 32,
    parameter logic [31:0] KIND_MASK = 32'h0
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] irq_in,
    input logic [NUM_SRC-1:0] stat,
    input logic [NUM_SRC-1:0] ack,
    input logic [NUM_SRC-1:0] pend,
    input logic [1:0]         mstr,
    input logic [31:0]        vec,
    input logic               irq_out
);

    localparam logic [NUM_SRC-1:0] EDGE_M  = KIND_MASK[NUM_SRC-1:0];
    localparam logic [NUM_SRC-1:0] LEVEL_M = ~KIND_MASK[NUM_SRC-1:0];

    // Set once a full clocked cycle has passed since reset, so $past is meaningful.
    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R2: a high level line with no acknowledge is latched on the next cycle
    assert_level_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> ((($past(irq_in) & ~$past(ack) & LEVEL_M) & ~stat) == '0));

    // R3: an edge bit never drops without an acknowledge
    assert_edge_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> ((($past(stat) & ~$past(ack) & EDGE_M) & ~stat) == '0));

    // R8: no pending line means the all-ones vector
    assert_vec_none_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> (vec == 32'hFFFF_FFFF));

    // R8: a reported vector is pending and nothing below it is
    assert_vec_lowest_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (vec != 32'hFFFF_FFFF) |->
            (vec < NUM_SRC && pend[vec[4:0]] &&
             ((32'(pend) & ((32'd1 << vec[4:0]) - 32'd1)) == 32'd0)));

    // R9: the processor line follows the gated request one cycle later
    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (irq_out == ($past(pend) != '0 && $past(mstr) == 2'b11)));

endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
    .NUM_SRC   (NUM_SRC),
    .KIND_MASK (KIND_MASK)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_in  (irq_in),
    .stat    (stat_w),
    .ack     (ack_w),
    .pend    (pend_w),
    .mstr    (mstr_q),
    .vec     (vec_w),
    .irq_out (irq_out)
);

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;

    localparam int     CLK_PERIOD = 10;
    localparam int     N          = 8;
    localparam [31:0]  KIND       = 32'h8000_00F0; // lines 4..7 edge, bit 31 beyond range
    localparam [4:0]   A_STAT = 5'h00, A_PEND = 5'h04, A_EN = 5'h08, A_ACK = 5'h0C,
                       A_SET  = 5'h10, A_CLR  = 5'h14, A_VEC = 5'h18, A_CTRL = 5'h1C;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] irq_in = '0;
    logic [4:0]   reg_addr = '0;
    logic         reg_wr = 1'b0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         irq_out;

    int n_vec = 0;
    int n_bad = 0;

    irq_vector_ctrl #(.NUM_SRC(N), .KIND_MASK(KIND)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input [31:0] act, input [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input [4:0] a, input [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input [4:0] a, input [31:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    function automatic [31:0] lowest(input [N-1:0] p);
        lowest = 32'hFFFF_FFFF;
        for (int i = N - 1; i >= 0; i--) if (p[i]) lowest = i;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd_check("R1 status", A_STAT, 0);
        rd_check("R1 enable", A_EN, 0);
        rd_check("R1 ctrl", A_CTRL, 0);
        rd_check("R1 vector", A_VEC, 32'hFFFF_FFFF);
        check("R1 irq", {31'd0, irq_out}, 0);

        // R11 read-only and misaligned writes ignored
        wr(A_EN, 32'h0F);
        wr(A_STAT, 32'hFF); wr(A_PEND, 32'hFF); wr(A_VEC, 32'h3);
        wr(5'h09, 32'hF0);  wr(5'h1E, 32'h3);
        rd_check("R11 status", A_STAT, 0);
        rd_check("R11 pending", A_PEND, 0);
        rd_check("R11 vector", A_VEC, 32'hFFFF_FFFF);
        rd_check("R11 enable", A_EN, 32'h0F);
        rd_check("R11 ctrl", A_CTRL, 0);
        wr(A_EN, 0);

        // R2 level line 1
        @(negedge clk); irq_in[1] = 1'b1;
        @(negedge clk);
        rd_check("R2 latch", A_STAT, 32'h02);
        wr(A_ACK, 32'h02);
        rd_check("R2 ack dip", A_STAT, 32'h00);
        @(negedge clk);
        rd_check("R2 relatch", A_STAT, 32'h02);
        irq_in[1] = 1'b0;
        repeat (2) @(negedge clk);
        rd_check("R2 held low", A_STAT, 32'h02);
        wr(A_ACK, 32'h02);
        @(negedge clk);
        rd_check("R2 cleared", A_STAT, 32'h00);

        // R3 edge line 5
        irq_in[5] = 1'b1;
        @(negedge clk);
        rd_check("R3 edge set", A_STAT, 32'h20);
        irq_in[5] = 1'b0;
        repeat (2) @(negedge clk);
        rd_check("R3 holds", A_STAT, 32'h20);
        wr(A_ACK, 32'h20);
        rd_check("R3 ack", A_STAT, 32'h00);
        irq_in[5] = 1'b1;
        @(negedge clk);
        wr(A_ACK, 32'h20);
        repeat (2) @(negedge clk);
        rd_check("R3 no relatch", A_STAT, 32'h00);
        irq_in[5] = 1'b0;

        // R4 acknowledge masks
        @(negedge clk); irq_in = '1;
        @(negedge clk); irq_in = '0;
        @(negedge clk);
        rd_check("R4 all set", A_STAT, 32'hFF);
        wr(A_ACK, 32'h0);
        rd_check("R4 zero ack", A_STAT, 32'hFF);
        wr(A_ACK, 32'h05);
        rd_check("R4 partial", A_STAT, 32'hFA);
        wr(A_ACK, 32'hFFFF_FFFF);
        rd_check("R4 all clear", A_STAT, 32'h00);

        // R6 direct write and unused bits
        wr(A_EN, 32'hFFFF_FFFF);
        rd_check("R6 unused zero", A_EN, 32'hFF);
        wr(A_EN, 32'h0);
        rd_check("R6 replace", A_EN, 32'h0);

        // R5 set / clear atomic, walking each bit beside a neighbour
        for (int i = 0; i < N; i++) begin
            automatic int j = (i + 3) % N;
            wr(A_EN, 32'(1) << j);
            wr(A_SET, 32'(1) << i);
            rd_check("R5 set", A_EN, (32'(1) << i) | (32'(1) << j));
            if (i != j) begin
                wr(A_CLR, 32'(1) << i);
                rd_check("R5 clear", A_EN, 32'(1) << j);
            end
        end

        // R7 R8 R9 exhaustive enable sweep with every request latched
        wr(A_CTRL, 32'h3);
        @(negedge clk); irq_in = '1;
        @(negedge clk);
        for (int p = 0; p < 256; p++) begin
            wr(A_EN, p);
            rd_check("R7 pending", A_PEND, p);
            rd_check("R8 vector", A_VEC, lowest(p[N-1:0]));
            @(negedge clk);
            check("R9 irq", {31'd0, irq_out}, (p != 0) ? 1 : 0);
        end

        // R10 control readback, R9 gating by each control bit
        wr(A_EN, 32'h10);
        for (int m = 0; m < 4; m++) begin
            wr(A_CTRL, 32'hFFFF_FFFC | m);
            rd_check("R10 readback", A_CTRL, m);
            @(negedge clk);
            check("R9 ctrl gate", {31'd0, irq_out}, (m == 3) ? 1 : 0);
        end
        irq_in = '0;

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule